// File: doc/BRIEF.md
# Banked program counter and stack sequencer

This block is the program-flow unit of a small microcontroller. It keeps a 12-bit program counter over a 4K-word space that is split into two 2K banks. It also keeps a bank-select bit that is only applied later, an eight-entry return stack whose entries pair a return address with four status bits, and eight 8-bit working registers that serve as loop counters. Each cycle an instruction decoder may present one flow request on `op_code`, qualified by `op_valid`. The ALU supplies the branch condition, the accumulator and new flag values. A byte fetched from program memory completes an indirect jump.

The bank-select commands only change a pending bit. That bit reaches address bit 11 when a far jump or a call executes. A plain increment wraps inside the current bank, and in-page branches replace only the low eight address bits. A call saves the return address and the upper status nibble. There are two returns. One restores only the address. The other also restores the nibble and marks the end of an interrupt service routine. Neither return touches the pending bank bit.

Top module: `pflow_seq`

## Requirements
- R1: After a synchronous active-high reset, `pc_q` is 0x000, `bank_pend_q` is 0, `status_q` is 0x08, `ind_req_q` and `isr_done_q` are 0, and every working register reads 0.
- R2: An accepted step (op 4'h0, and any unused code) adds one to `pc_q[10:0]`, wrapping 0x7FF to 0x000, and leaves `pc_q[11]` unchanged.
- R3: Bank select (op 4'h1 picks bank 0, op 4'h2 picks bank 1) sets only `bank_pend_q` and steps the counter. A far jump (op 4'h3) loads `{bank_pend_q, imm}`. The pending bit stays in force for every later jump and call.
- R4: A conditional jump (op 4'h5) with `cond_in` high replaces `pc_q[7:0]` with `imm[7:0]`. With `cond_in` low it steps.
- R5: Decrement-and-jump (op 4'h6) decrements the working register addressed by `reg_sel` and shows the new value on `wreg_q`. When the new value is nonzero it replaces `pc_q[7:0]` with `imm[7:0]`, otherwise it steps. A register holding 0x00 becomes 0xFF and branches. A register load (op 4'hA) writes `imm[7:0]` into the addressed register, shows it on `wreg_q`, and steps.
- R6: An indirect jump (op 4'h7) raises `ind_req_q` for one cycle with `ind_addr_q = {pc_q[11:8], acc_in}`. In the following cycle `pc_q[7:0]` takes `ind_byte`.
- R7: A call (op 4'h4) pushes the stepped return address together with `status_q[7:4]`, increments the stack pointer, and loads `{bank_pend_q, imm}`.
- R8: A plain return (op 4'h8) pops the full 12-bit address into `pc_q` and decrements the stack pointer. It leaves `bank_pend_q` and `status_q[7:4]` unchanged.
- R9: A status return (op 4'h9) also restores `status_q[7:4]` from the popped entry and pulses `isr_done_q` high for exactly one cycle. The restore wins over a `flag_we` write in the same cycle.
- R10: The stack pointer is shown in `status_q[2:0]` with `status_q[3]` fixed at 1. It wraps modulo 8, so a ninth call overwrites the oldest entry.
- R11: `flag_we` high loads `flag_in` into `status_q[7:4]` on the next edge, whatever the request.
- R12: While `ind_req_q` is high, the request on the ports is ignored.
- R13: With `op_valid` low, the counter, bank bit, stack pointer and working registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A flow request is present |
| op_code | input | 4 | Request code |
| imm | input | 11 | Branch target or register load value |
| reg_sel | input | 3 | Working register index |
| cond_in | input | 1 | Branch condition from the ALU |
| acc_in | input | 8 | Accumulator, the offset for an indirect jump |
| ind_byte | input | 8 | Program-memory byte that completes an indirect jump |
| flag_we | input | 1 | Write enable for the status nibble |
| flag_in | input | 4 | New status nibble (carry, aux carry, F0, register bank) |
| pc_q | output | 12 | Program counter |
| bank_pend_q | output | 1 | Pending program bank |
| status_q | output | 8 | Status nibble, fixed 1, stack pointer |
| ind_req_q | output | 1 | Indirect fetch in progress |
| ind_addr_q | output | 12 | Program-memory address for the indirect fetch |
| isr_done_q | output | 1 | One-cycle end-of-interrupt-service pulse |
| wreg_q | output | 8 | Value last written to a working register |

## Verification
The status nibble has two writers that can fire in the same cycle: the ALU flag write and the restore done by a status return. The bench sets up a call with one nibble saved. It then writes a second nibble, and finally issues the status return while `flag_we` carries a third value. The status return must leave the saved nibble on `status_q[7:4]`, the caller's address on `pc_q` and a single `isr_done_q` pulse, with the competing flag value discarded.

// File: rtl/pflow_pkg.sv
package pflow_pkg;

  typedef enum logic [3:0] {
    OP_STEP  = 4'h0,
    OP_BANK0 = 4'h1,
    OP_BANK1 = 4'h2,
    OP_JFAR  = 4'h3,
    OP_CALL  = 4'h4,
    OP_JCND  = 4'h5,
    OP_DJNZ  = 4'h6,
    OP_JIND  = 4'h7,
    OP_RET   = 4'h8,
    OP_RETS  = 4'h9,
    OP_LDR   = 4'hA
  } pf_op_e;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_INC,
    PC_FAR,
    PC_PAGE,
    PC_IND,
    PC_POP
  } pc_sel_e;

  typedef struct packed {
    pc_sel_e pc_sel;
    logic    push;
    logic    pop;
    logic    restore;
    logic    set_bank;
    logic    bank_val;
    logic    reg_load;
    logic    reg_dec;
    logic    ind_start;
  } pf_ctrl_t;

endpackage

// File: rtl/pflow_decode.sv
module pflow_decode
  import pflow_pkg::*;
(
  input  logic       op_valid,
  input  logic [3:0] op_code,
  input  logic       busy,
  input  logic       cond_in,
  input  logic       dec_nz,
  output pf_ctrl_t   ctrl
);

  pf_op_e op;
  assign op = pf_op_e'(op_code);

  always_comb begin
    ctrl = '0;
    ctrl.pc_sel = PC_HOLD;
    if (busy) begin
      // second half of an indirect jump: the port request is dropped
      ctrl.pc_sel = PC_IND;
    end else if (op_valid) begin
      unique case (op)
        OP_BANK0: begin
          ctrl.pc_sel   = PC_INC;
          ctrl.set_bank = 1'b1;
          ctrl.bank_val = 1'b0;
        end
        OP_BANK1: begin
          ctrl.pc_sel   = PC_INC;
          ctrl.set_bank = 1'b1;
          ctrl.bank_val = 1'b1;
        end
        OP_JFAR:  ctrl.pc_sel = PC_FAR;
        OP_CALL: begin
          ctrl.pc_sel = PC_FAR;
          ctrl.push   = 1'b1;
        end
        OP_JCND:  ctrl.pc_sel = cond_in ? PC_PAGE : PC_INC;
        OP_DJNZ: begin
          ctrl.reg_dec = 1'b1;
          ctrl.pc_sel  = dec_nz ? PC_PAGE : PC_INC;
        end
        OP_JIND: begin
          ctrl.pc_sel    = PC_HOLD;
          ctrl.ind_start = 1'b1;
        end
        OP_RET: begin
          ctrl.pc_sel = PC_POP;
          ctrl.pop    = 1'b1;
        end
        OP_RETS: begin
          ctrl.pc_sel  = PC_POP;
          ctrl.pop     = 1'b1;
          ctrl.restore = 1'b1;
        end
        OP_LDR: begin
          ctrl.pc_sel   = PC_INC;
          ctrl.reg_load = 1'b1;
        end
        default:  ctrl.pc_sel = PC_INC;
      endcase
    end
  end

endmodule

// File: rtl/pflow_pc.sv
module pflow_pc
  import pflow_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_sel_e           pc_sel,
  input  logic [PC_W-2:0]   imm,
  input  logic [PAGE_W-1:0] ind_byte,
  input  logic [PC_W-1:0]   pop_addr,
  input  logic              set_bank,
  input  logic              bank_val,
  output logic [PC_W-1:0]   pc_q,
  output logic              bank_q,
  output logic [PC_W-1:0]   pc_inc
);

  localparam int OFF_W = PC_W - 1;

  logic [PC_W-1:0] pc_nxt;

  // bank bit is never touched by the increment
  assign pc_inc = {pc_q[PC_W-1], pc_q[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1}};

  always_comb begin
    unique case (pc_sel)
      PC_INC:  pc_nxt = pc_inc;
      PC_FAR:  pc_nxt = {bank_q, imm};
      PC_PAGE: pc_nxt = {pc_q[PC_W-1:PAGE_W], imm[PAGE_W-1:0]};
      PC_IND:  pc_nxt = {pc_q[PC_W-1:PAGE_W], ind_byte};
      PC_POP:  pc_nxt = pop_addr;
      default: pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      bank_q <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (set_bank) bank_q <= bank_val;
    end
  end

endmodule

// File: rtl/pflow_stack.sv
module pflow_stack #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 16,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] din,
  output logic [ENT_W-1:0] dout,
  output logic [SP_W-1:0]  sp_q
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp_dn;

  assign sp_dn = sp_q - {{(SP_W-1){1'b0}}, 1'b1};
  assign dout  = mem[sp_dn];

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= din;
  end

  // pointer wraps modulo DEPTH
  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + {{(SP_W-1){1'b0}}, 1'b1};
    else if (pop)  sp_q <= sp_dn;
  end

endmodule

// File: rtl/pflow_wregs.sv
module pflow_wregs #(
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              load,
  input  logic              dec,
  input  logic [DATA_W-1:0] ld_val,
  output logic              dec_nz,
  output logic [DATA_W-1:0] wreg_q
);

  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] rd, dec_val;

  assign rd      = rf[sel];
  assign dec_val = rd - {{(DATA_W-1){1'b0}}, 1'b1};
  assign dec_nz  = |dec_val;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (rst)              rf[g] <= '0;
      else if (hit && load) rf[g] <= ld_val;
      else if (hit && dec)  rf[g] <= dec_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       wreg_q <= '0;
    else if (load) wreg_q <= ld_val;
    else if (dec)  wreg_q <= dec_val;
  end

endmodule

// File: rtl/pflow_seq.sv
module pflow_seq
  import pflow_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 8,
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            op_valid,
  input  logic [3:0]                      op_code,
  input  logic [PC_W-2:0]                 imm,
  input  logic [$clog2(NREG)-1:0]         reg_sel,
  input  logic                            cond_in,
  input  logic [PAGE_W-1:0]               acc_in,
  input  logic [PAGE_W-1:0]               ind_byte,
  input  logic                            flag_we,
  input  logic [STAT_W-1:0]               flag_in,
  output logic [PC_W-1:0]                 pc_q,
  output logic                            bank_pend_q,
  output logic [STAT_W+$clog2(DEPTH):0]   status_q,
  output logic                            ind_req_q,
  output logic [PC_W-1:0]                 ind_addr_q,
  output logic                            isr_done_q,
  output logic [DATA_W-1:0]               wreg_q
);

  localparam int SP_W  = $clog2(DEPTH);
  localparam int ENT_W = STAT_W + PC_W;

  pf_ctrl_t          ctrl;
  logic              dec_nz;
  logic [PC_W-1:0]   pc_inc;
  logic [ENT_W-1:0]  stk_din, stk_dout;
  logic [SP_W-1:0]   sp_q;
  logic [STAT_W-1:0] stat_q;
  logic              accepted;

  assign accepted = op_valid && !ind_req_q;

  pflow_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .busy     (ind_req_q),
    .cond_in  (cond_in),
    .dec_nz   (dec_nz),
    .ctrl     (ctrl)
  );

  pflow_pc #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .pc_sel   (ctrl.pc_sel),
    .imm      (imm),
    .ind_byte (ind_byte),
    .pop_addr (stk_dout[PC_W-1:0]),
    .set_bank (ctrl.set_bank),
    .bank_val (ctrl.bank_val),
    .pc_q     (pc_q),
    .bank_q   (bank_pend_q),
    .pc_inc   (pc_inc)
  );

  assign stk_din = {stat_q, pc_inc};

  pflow_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (ctrl.push),
    .pop  (ctrl.pop),
    .din  (stk_din),
    .dout (stk_dout),
    .sp_q (sp_q)
  );

  pflow_wregs #(.NREG(NREG), .DATA_W(DATA_W)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .sel    (reg_sel),
    .load   (ctrl.reg_load),
    .dec    (ctrl.reg_dec),
    .ld_val (imm[DATA_W-1:0]),
    .dec_nz (dec_nz),
    .wreg_q (wreg_q)
  );

  // status nibble: restore from stack outranks the ALU write
  always_ff @(posedge clk) begin
    if (rst)               stat_q <= '0;
    else if (ctrl.restore) stat_q <= stk_dout[ENT_W-1:PC_W];
    else if (flag_we)      stat_q <= flag_in;
  end

  assign status_q = {stat_q, 1'b1, sp_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_req_q  <= 1'b0;
      ind_addr_q <= '0;
      isr_done_q <= 1'b0;
    end else begin
      ind_req_q  <= ctrl.ind_start;
      isr_done_q <= ctrl.restore;
      if (ctrl.ind_start) ind_addr_q <= {pc_q[PC_W-1:PAGE_W], acc_in};
    end
  end

endmodule

// File: rtl/pflow_seq_chk.sv
module pflow_seq_chk #(
  parameter int PC_W  = 12,
  parameter int SP_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic            accepted,
  input logic [PC_W-1:0] pc_q,
  input logic            bank_pend_q,
  input logic [SP_W-1:0] sp_q,
  input logic            ind_req_q,
  input logic            isr_done_q
);

  // R2: a step never changes the bank bit of the counter
  assert_step_keeps_bank_R2: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_code == 4'h0) |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]));

  // R3: bank select does not move address bit 11
  assert_select_pending_only_R3: assert property (@(posedge clk) disable iff (rst)
    (accepted && (op_code == 4'h1 || op_code == 4'h2)) |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]));

  // R4: conditional jump stays inside the page
  assert_jcond_in_page_R4: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_code == 4'h5) |=> pc_q[PC_W-1:8] == $past(pc_q[PC_W-1:8]));

  // R7: call advances the stack pointer by one
  assert_call_pushes_R7: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_code == 4'h4) |=> sp_q == $past(sp_q) + 1'b1);

  // R8: return leaves the pending bank alone
  assert_ret_keeps_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (accepted && (op_code == 4'h8 || op_code == 4'h9)) |=> bank_pend_q == $past(bank_pend_q));

  // R9: end-of-service pulse lasts one cycle and follows a status return
  assert_isr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    isr_done_q |=> !isr_done_q);
  assert_isr_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_done_q) |-> $past(accepted && op_code == 4'h9));

  // R12: the indirect fetch occupies exactly one cycle
  assert_ind_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    ind_req_q |=> !ind_req_q);

  // R13: no request, no movement
  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !ind_req_q) |=> ($stable(pc_q) && $stable(sp_q) && $stable(bank_pend_q)));

endmodule

bind pflow_seq pflow_seq_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .accepted    (accepted),
  .pc_q        (pc_q),
  .bank_pend_q (bank_pend_q),
  .sp_q        (sp_q),
  .ind_req_q   (ind_req_q),
  .isr_done_q  (isr_done_q)
);

// File: tb/pflow_seq_tb_top.sv
module pflow_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [10:0] imm;
  logic [2:0]  reg_sel;
  logic        cond_in;
  logic [7:0]  acc_in;
  logic [7:0]  ind_byte;
  logic        flag_we;
  logic [3:0]  flag_in;
  logic [11:0] pc_q;
  logic        bank_pend_q;
  logic [7:0]  status_q;
  logic        ind_req_q;
  logic [11:0] ind_addr_q;
  logic        isr_done_q;
  logic [7:0]  wreg_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pflow_seq dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .imm(imm),
    .reg_sel(reg_sel), .cond_in(cond_in), .acc_in(acc_in), .ind_byte(ind_byte),
    .flag_we(flag_we), .flag_in(flag_in), .pc_q(pc_q), .bank_pend_q(bank_pend_q),
    .status_q(status_q), .ind_req_q(ind_req_q), .ind_addr_q(ind_addr_q),
    .isr_done_q(isr_done_q), .wreg_q(wreg_q)
  );

  // {req, op, imm, sel, cond, expected pc}
  localparam int NV = 17;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2,  4'h0, 11'h000, 3'd0, 1'b0, 12'h001},  // R2 step
    {4'd5,  4'hA, 11'h002, 3'd2, 1'b0, 12'h002},  // R5 load r2=2
    {4'd3,  4'h3, 11'h123, 3'd0, 1'b0, 12'h123},  // R3 far jump bank 0
    {4'd4,  4'h5, 11'h045, 3'd0, 1'b1, 12'h145},  // R4 taken
    {4'd4,  4'h5, 11'h0AA, 3'd0, 1'b0, 12'h146},  // R4 not taken
    {4'd5,  4'h6, 11'h010, 3'd2, 1'b0, 12'h110},  // R5 2->1 branch
    {4'd5,  4'h6, 11'h020, 3'd2, 1'b0, 12'h111},  // R5 1->0 fall through
    {4'd3,  4'h2, 11'h000, 3'd0, 1'b0, 12'h112},  // R3 select bank 1, pending only
    {4'd3,  4'h0, 11'h000, 3'd0, 1'b0, 12'h113},  // R3 step keeps bank 0
    {4'd3,  4'h3, 11'h7FF, 3'd0, 1'b0, 12'hFFF},  // R3 far jump applies bank 1
    {4'd2,  4'h0, 11'h000, 3'd0, 1'b0, 12'h800},  // R2 wrap inside bank 1
    {4'd7,  4'h4, 11'h050, 3'd0, 1'b0, 12'h850},  // R7 call, bank still 1
    {4'd3,  4'h1, 11'h000, 3'd0, 1'b0, 12'h851},  // R3 select bank 0
    {4'd8,  4'h8, 11'h000, 3'd0, 1'b0, 12'h801},  // R8 return to caller bank
    {4'd8,  4'h3, 11'h200, 3'd0, 1'b0, 12'h200},  // R8 pending 0 survived return
    {4'd3,  4'h3, 11'h7FF, 3'd0, 1'b0, 12'h7FF},  // R3
    {4'd2,  4'h0, 11'h000, 3'd0, 1'b0, 12'h000}   // R2 wrap inside bank 0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [10:0] im,
                       input logic [2:0] s, input logic c);
    op_valid = 1'b1;
    op_code  = o;
    imm      = im;
    reg_sel  = s;
    cond_in  = c;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    op_valid = 1'b0; op_code = 4'h0; imm = '0; reg_sel = '0; cond_in = 1'b0;
    acc_in = '0; ind_byte = '0; flag_we = 1'b0; flag_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    reset_dut();

    // R1 reset state
    check("R1 pc", pc_q, 12'h000);
    check("R1 bank", bank_pend_q, 1'b0);
    check("R1 status", status_q, 8'h08);
    check("R1 ind_req", ind_req_q, 1'b0);
    check("R1 isr_done", isr_done_q, 1'b0);
    check("R1 wreg", wreg_q, 8'h00);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      do_op(v[30:27], v[26:16], v[15:13], v[12]);
      check($sformatf("R%0d vec%0d pc", v[34:31], i), pc_q, v[11:0]);
    end
    check("R10 sp back to zero", status_q, 8'h08);

    // R13 idle holds
    @(negedge clk);
    check("R13 idle pc", pc_q, 12'h000);

    // R5 zero register wraps to 0xFF and branches
    reset_dut();
    do_op(4'h6, 11'h033, 3'd5, 1'b0);
    check("R5 wrap wreg", wreg_q, 8'hFF);
    check("R5 wrap pc", pc_q, 12'h033);
    do_op(4'hA, 11'h001, 3'd5, 1'b0);
    check("R5 load wreg", wreg_q, 8'h01);
    do_op(4'h6, 11'h077, 3'd5, 1'b0);
    check("R5 to zero wreg", wreg_q, 8'h00);
    check("R5 to zero pc", pc_q, 12'h035);

    // R6 / R12 indirect jump
    reset_dut();
    do_op(4'h3, 11'h345, 3'd0, 1'b0);
    acc_in = 8'h9A;
    do_op(4'h7, 11'h000, 3'd0, 1'b0);
    check("R6 ind_req", ind_req_q, 1'b1);
    check("R6 ind_addr", ind_addr_q, 12'h39A);
    check("R6 pc held", pc_q, 12'h345);
    ind_byte = 8'h5C;
    do_op(4'h2, 11'h000, 3'd0, 1'b0);  // select bank 1 while busy: ignored
    check("R6 pc low byte", pc_q, 12'h35C);
    check("R6 ind_req drop", ind_req_q, 1'b0);
    check("R12 ignored select", bank_pend_q, 1'b0);

    // R9 / R11 status return racing a flag write
    reset_dut();
    flag_we = 1'b1; flag_in = 4'hA;
    @(negedge clk);
    flag_we = 1'b0;
    check("R11 flag write", status_q, 8'hA8);
    check("R13 flag write alone holds pc", pc_q, 12'h000);
    do_op(4'h4, 11'h300, 3'd0, 1'b0);
    check("R7 call pc", pc_q, 12'h300);
    check("R7 call status", status_q, 8'hA9);
    flag_we = 1'b1; flag_in = 4'h5;
    @(negedge clk);
    check("R11 flag in subroutine", status_q, 8'h59);
    flag_in = 4'hC;
    do_op(4'h9, 11'h000, 3'd0, 1'b0);
    flag_we = 1'b0;
    check("R9 restore wins", status_q, 8'hA8);
    check("R9 return pc", pc_q, 12'h001);
    check("R9 isr pulse", isr_done_q, 1'b1);
    do_op(4'h0, 11'h000, 3'd0, 1'b0);
    check("R9 isr pulse ends", isr_done_q, 1'b0);
    check("R9 step after", pc_q, 12'h002);

    // R10 stack wrap: nine calls, then two returns
    reset_dut();
    for (int k = 1; k <= 9; k++) do_op(4'h4, 11'(k * 16), 3'd0, 1'b0);
    check("R10 pc after nine calls", pc_q, 12'h090);
    check("R10 sp wrapped", status_q, 8'h09);
    do_op(4'h8, 11'h000, 3'd0, 1'b0);
    check("R10 newest return", pc_q, 12'h081);
    check("R10 sp zero", status_q, 8'h08);
    do_op(4'h8, 11'h000, 3'd0, 1'b0);
    check("R10 wrapped return", pc_q, 12'h071);
    check("R10 sp seven", status_q, 8'h0F);

    finish_run();
  end

endmodule